// File: doc/BRIEF.md
# Configurable Peripheral I/O Chip-Select Decoder

This block turns a PC-compatible I/O address into chip selects for two serial ports and one floppy controller. Software programs where each device appears by writing word-wide configuration registers that sit at four fixed I/O ports. The registers accept word accesses and single-byte accesses, and a byte write merges into the stored word.

Each serial port has a 3-bit base code that picks one of four legacy base addresses or leaves the port unmapped. A separate disable bit overrides the code. When a serial port is mapped, its interrupt number is driven out. The floppy controller has a single enable bit for its fixed base. The chip selects are a pure address decode. They follow the address and the register contents in the same cycle and do not depend on the read or write strobes.

Top module: `periphIoDecoder`

## Requirements
- R1: Four 16-bit configuration registers are decoded at I/O addresses 0x2072 (serial config), 0x2872 (floppy config), 0x5872 and 0xF872. Address bit 0 is ignored when a register is selected, so the odd byte address of each pair reaches the same register.
- R2: A write applies lane by lane. `byteEn[0]` writes bits 7:0 from `wrData[7:0]`, `byteEn[1]` writes bits 15:8 from `wrData[15:8]`, and a lane whose strobe is low keeps its stored value.
- R3: A read is captured on the clock edge that samples `ioRd`, and `rdData` shows the result from that edge onward, holding it until the next read. The result is the register word on a hit, 0xFFFF when `ioAddr[10:0]` is 0x072 or 0x073 but no register matches, and 0x0000 otherwise.
- R4: Serial port A is controlled by bits 7:5 (code) and bit 4 (disable) of the serial config register. When bit 4 is set the port is unmapped. Code 1 selects 0x3F8, code 2 selects 0x2F8, code 3 selects 0x3E8 and code 4 selects 0x2E8. Codes 0, 5, 6 and 7 leave the port unmapped.
- R5: Serial port B uses bits 3:1 as its code and bit 0 as its disable, with the same code-to-base mapping as serial port A.
- R6: A mapped serial port's select asserts for the eight addresses starting at its base (the address matches the base in bits 15:3), combinationally and regardless of `ioRd`/`ioWr`.
- R7: When both serial ports decode the same address, only `csSerA` asserts.
- R8: `csFloppy` asserts for 0x3F0 to 0x3F7 while bit 0 of the floppy config register is clear. When that bit is set, the floppy controller is unmapped.
- R9: `irqSerA` is 4 while serial port A is mapped and 0 otherwise. `irqSerB` is 3 while serial port B is mapped and 0 otherwise.
- R10: Reset (active-low `rstN`) clears all registers and `rdData` to zero. Both serial ports are then unmapped and the floppy controller is enabled.
- R11: The registers at 0x5872 and 0xF872 are read/write storage only, and their contents do not change any select or IRQ output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioAddr | input | 16 | I/O address |
| wrData | input | 16 | Write data, high lane in bits 15:8 |
| byteEn | input | 2 | Byte-lane strobes, bit 0 low lane, bit 1 high lane |
| ioRd | input | 1 | Read strobe |
| ioWr | input | 1 | Write strobe |
| rdData | output | 16 | Registered read data |
| csSerA | output | 1 | Serial port A chip select |
| csSerB | output | 1 | Serial port B chip select |
| csFloppy | output | 1 | Floppy controller chip select |
| irqSerA | output | 4 | Interrupt number routed to serial port A (0 = none) |
| irqSerB | output | 4 | Interrupt number routed to serial port B (0 = none) |

## Verification
The bench probes both ends of every 8-byte window and the address just past each window. A design that compared too few or too many address bits would select a neighbouring device or miss the top byte. It programs both serial ports onto one base to catch a decoder that asserts two selects at once, and it drives the unused codes and the disable bits to catch a port left mapped. Single-lane writes, including writes through the odd address of a pair, expose a merge that clobbers the other byte or picks the wrong lane. Reads from unassigned addresses inside and outside the 0x072 window separate the 0xFFFF and 0x0000 results.

// File: rtl/pioDecPkg.sv
package pioDecPkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 16;
  localparam int LANE_CNT = DATA_W / 8;
  localparam int REG_CNT  = 4;
  localparam int WIN_MSB  = 10;
  localparam int SER_CNT  = 2;

  localparam int IDX_SER   = 0;
  localparam int IDX_FDC   = 1;
  localparam int IDX_STOR0 = 2;
  localparam int IDX_STOR1 = 3;

  localparam logic [ADDR_W-1:0] FDC_BASE = 16'h03F0;

  function automatic logic [ADDR_W-1:0] portOf(input int idx);
    case (idx)
      IDX_SER:   portOf = 16'h2072;
      IDX_FDC:   portOf = 16'h2872;
      IDX_STOR0: portOf = 16'h5872;
      default:   portOf = 16'hF872;
    endcase
  endfunction

  // Returns {valid, base} for a serial base code.
  function automatic logic [ADDR_W:0] serBase(input logic [2:0] code);
    case (code)
      3'd1:    serBase = {1'b1, 16'h03F8};
      3'd2:    serBase = {1'b1, 16'h02F8};
      3'd3:    serBase = {1'b1, 16'h03E8};
      3'd4:    serBase = {1'b1, 16'h02E8};
      default: serBase = '0;
    endcase
  endfunction

  typedef struct packed {
    logic [REG_CNT-1:0]  wrSel;
    logic [REG_CNT-1:0]  rdSel;
    logic [LANE_CNT-1:0] laneWr;
    logic                rdEn;
    logic                rdMiss;
  } ctrlStrobe_t;
endpackage

// File: rtl/pioDecCtrl.sv
module pioDecCtrl
  import pioDecPkg::*;
(
  input  logic [ADDR_W-1:0]   ioAddr,
  input  logic [LANE_CNT-1:0] byteEn,
  input  logic                ioRd,
  input  logic                ioWr,
  output ctrlStrobe_t         strobe
);
  localparam logic [ADDR_W-1:0] WIN_PORT = portOf(0);

  logic [REG_CNT-1:0] regHit;
  logic               windowHit;

  assign windowHit = (ioAddr[WIN_MSB:1] == WIN_PORT[WIN_MSB:1]);

  for (genvar i = 0; i < REG_CNT; i++) begin : g_match
    localparam logic [ADDR_W-1:0] PORT = portOf(i);
    assign regHit[i] = (ioAddr[ADDR_W-1:1] == PORT[ADDR_W-1:1]);
  end

  always_comb begin
    strobe.wrSel  = ioWr ? regHit : '0;
    strobe.rdSel  = regHit;
    strobe.laneWr = byteEn;
    strobe.rdEn   = ioRd;
    strobe.rdMiss = windowHit && (regHit == '0);
  end
endmodule

// File: rtl/pioDecRegs.sv
module pioDecRegs
  import pioDecPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  ctrlStrobe_t       strobe,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] cfgSer,
  output logic [DATA_W-1:0] cfgFdc
);
  logic [DATA_W-1:0] cfgWord [REG_CNT];
  logic [DATA_W-1:0] muxWord;

  for (genvar r = 0; r < REG_CNT; r++) begin : g_reg
    for (genvar l = 0; l < LANE_CNT; l++) begin : g_lane
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          cfgWord[r][l*8 +: 8] <= '0;
        else if (strobe.wrSel[r] && strobe.laneWr[l])
          cfgWord[r][l*8 +: 8] <= wrData[l*8 +: 8];
      end
    end
  end

  always_comb begin
    muxWord = '0;
    for (int r = 0; r < REG_CNT; r++)
      if (strobe.rdSel[r]) muxWord = muxWord | cfgWord[r];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rdData <= '0;
    else if (strobe.rdEn) begin
      if (strobe.rdSel != '0) rdData <= muxWord;
      else if (strobe.rdMiss) rdData <= '1;
      else                    rdData <= '0;
    end
  end

  assign cfgSer = cfgWord[IDX_SER];
  assign cfgFdc = cfgWord[IDX_FDC];
endmodule

// File: rtl/pioDecSel.sv
module pioDecSel
  import pioDecPkg::*;
#(
  parameter int IRQ_W = 4,
  parameter int IRQ_A = 4,
  parameter int IRQ_B = 3
) (
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] cfgSer,
  input  logic [DATA_W-1:0] cfgFdc,
  output logic              csSerA,
  output logic              csSerB,
  output logic              csFloppy,
  output logic [IRQ_W-1:0]  irqSerA,
  output logic [IRQ_W-1:0]  irqSerB
);
  logic [SER_CNT-1:0] mapped;
  logic [SER_CNT-1:0] hit;

  for (genvar ch = 0; ch < SER_CNT; ch++) begin : g_ser
    localparam int OFS = (ch == 0) ? 4 : 0;
    logic [ADDR_W:0] look;
    assign look       = serBase(cfgSer[OFS+3:OFS+1]);
    assign mapped[ch] = !cfgSer[OFS] && look[ADDR_W];
    assign hit[ch]    = mapped[ch] && (ioAddr[ADDR_W-1:3] == look[ADDR_W-1:3]);
  end

  assign csSerA   = hit[0];
  assign csSerB   = hit[1] && !hit[0];
  assign csFloppy = !cfgFdc[0] && (ioAddr[ADDR_W-1:3] == FDC_BASE[ADDR_W-1:3]);
  assign irqSerA  = mapped[0] ? IRQ_W'(IRQ_A) : '0;
  assign irqSerB  = mapped[1] ? IRQ_W'(IRQ_B) : '0;
endmodule

// File: rtl/periphIoDecoder.sv
module periphIoDecoder
  import pioDecPkg::*;
#(
  parameter int IRQ_W = 4,
  parameter int IRQ_A = 4,
  parameter int IRQ_B = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       ioAddr,
  input  logic [15:0]       wrData,
  input  logic [1:0]        byteEn,
  input  logic              ioRd,
  input  logic              ioWr,
  output logic [15:0]       rdData,
  output logic              csSerA,
  output logic              csSerB,
  output logic              csFloppy,
  output logic [IRQ_W-1:0]  irqSerA,
  output logic [IRQ_W-1:0]  irqSerB
);
  ctrlStrobe_t       strobe;
  logic [DATA_W-1:0] cfgSer;
  logic [DATA_W-1:0] cfgFdc;

  pioDecCtrl ctrl_i (
    .ioAddr (ioAddr),
    .byteEn (byteEn),
    .ioRd   (ioRd),
    .ioWr   (ioWr),
    .strobe (strobe)
  );

  pioDecRegs regs_i (
    .clk    (clk),
    .rstN   (rstN),
    .wrData (wrData),
    .strobe (strobe),
    .rdData (rdData),
    .cfgSer (cfgSer),
    .cfgFdc (cfgFdc)
  );

  pioDecSel #(.IRQ_W(IRQ_W), .IRQ_A(IRQ_A), .IRQ_B(IRQ_B)) sel_i (
    .ioAddr   (ioAddr),
    .cfgSer   (cfgSer),
    .cfgFdc   (cfgFdc),
    .csSerA   (csSerA),
    .csSerB   (csSerB),
    .csFloppy (csFloppy),
    .irqSerA  (irqSerA),
    .irqSerB  (irqSerB)
  );
endmodule

// File: rtl/periphIoDecoderChk.sv
module periphIoDecoderChk #(
  parameter int IRQ_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [15:0]      ioAddr,
  input logic [1:0]       byteEn,
  input logic             ioRd,
  input logic             ioWr,
  input logic [15:0]      rdData,
  input logic             csSerA,
  input logic             csSerB,
  input logic             csFloppy,
  input logic [IRQ_W-1:0] irqSerA,
  input logic [IRQ_W-1:0] irqSerB,
  input logic [15:0]      cfgSer,
  input logic [15:0]      cfgFdc
);
  logic unassigned;
  assign unassigned = (ioAddr[10:0] == 11'h072 || ioAddr[10:0] == 11'h073) &&
                      !(ioAddr[15:11] inside {5'd4, 5'd5, 5'd11, 5'd31});

  assert_cs_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({csSerA, csSerB, csFloppy}));

  assert_serA_disabled_R4: assert property (@(posedge clk) disable iff (!rstN)
    cfgSer[4] |-> !csSerA && irqSerA == '0);

  assert_serB_disabled_R5: assert property (@(posedge clk) disable iff (!rstN)
    cfgSer[0] |-> !csSerB && irqSerB == '0);

  assert_floppy_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    cfgFdc[0] |-> !csFloppy);

  assert_irq_routed_R9: assert property (@(posedge clk) disable iff (!rstN)
    csSerA |-> irqSerA == IRQ_W'(4));

  assert_lane_keep_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && byteEn == 2'b01 && ioAddr[15:1] == 15'h1039) |=> cfgSer[15:8] == $past(cfgSer[15:8]));

  assert_miss_ones_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && unassigned) |=> rdData == 16'hFFFF);
endmodule

bind periphIoDecoder periphIoDecoderChk #(.IRQ_W(IRQ_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .ioAddr   (ioAddr),
  .byteEn   (byteEn),
  .ioRd     (ioRd),
  .ioWr     (ioWr),
  .rdData   (rdData),
  .csSerA   (csSerA),
  .csSerB   (csSerB),
  .csFloppy (csFloppy),
  .irqSerA  (irqSerA),
  .irqSerB  (irqSerB),
  .cfgSer   (cfgSer),
  .cfgFdc   (cfgFdc)
);

// File: tb/periphIoDecoder_tb_top.sv
`timescale 1ns/1ps
module periphIoDecoder_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] ioAddr;
  logic [15:0] wrData;
  logic [1:0]  byteEn;
  logic        ioRd;
  logic        ioWr;
  logic [15:0] rdData;
  logic        csSerA, csSerB, csFloppy;
  logic [3:0]  irqSerA, irqSerB;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  periphIoDecoder dut_i (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .wrData(wrData), .byteEn(byteEn),
    .ioRd(ioRd), .ioWr(ioWr), .rdData(rdData), .csSerA(csSerA), .csSerB(csSerB),
    .csFloppy(csFloppy), .irqSerA(irqSerA), .irqSerB(irqSerB)
  );

  typedef struct packed {
    logic [15:0] ser;
    logic [15:0] fd;
    logic [15:0] probe;
    logic [2:0]  exp;   // {A, B, F}
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t VECS [NVEC] = '{
    '{16'h0020, 16'h0001, 16'h03F8, 3'b100},  // R4 code1 low edge
    '{16'h0020, 16'h0001, 16'h03FF, 3'b100},  // R6 top of window
    '{16'h0020, 16'h0001, 16'h0400, 3'b000},  // R6 past window
    '{16'h0040, 16'h0001, 16'h02FC, 3'b100},  // R4 code2
    '{16'h0060, 16'h0001, 16'h03E8, 3'b100},  // R4 code3
    '{16'h0080, 16'h0001, 16'h02EF, 3'b100},  // R4 code4
    '{16'h00A0, 16'h0001, 16'h03F8, 3'b000},  // R4 code5 unmapped
    '{16'h0030, 16'h0001, 16'h03F8, 3'b000},  // R4 disable bit
    '{16'h0002, 16'h0001, 16'h03F9, 3'b010},  // R5 code1
    '{16'h0004, 16'h0001, 16'h02F8, 3'b010},  // R5 code2
    '{16'h0006, 16'h0001, 16'h03EA, 3'b010},  // R5 code3
    '{16'h0008, 16'h0001, 16'h02E8, 3'b010},  // R5 code4
    '{16'h0003, 16'h0001, 16'h03F8, 3'b000},  // R5 disable bit
    '{16'h000E, 16'h0001, 16'h03F8, 3'b000},  // R5 code7 unmapped
    '{16'h0022, 16'h0001, 16'h03F8, 3'b100},  // R7 both on 0x3F8
    '{16'h0024, 16'h0001, 16'h02F8, 3'b010},  // R7 distinct bases
    '{16'h0000, 16'h0000, 16'h03F0, 3'b001},  // R8 low edge
    '{16'h0000, 16'h0000, 16'h03F7, 3'b001},  // R8 high edge
    '{16'h0000, 16'h0001, 16'h03F3, 3'b000},  // R8 disabled
    '{16'h0000, 16'h0100, 16'h03EF, 3'b000}   // R8 below window
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    ioAddr = a; wrData = d; byteEn = be; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic busRead(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    ioAddr = a; byteEn = 2'b11; ioRd = 1'b1;
    @(negedge clk);
    ioRd = 1'b0;
    d = rdData;
  endtask

  task automatic probe(input logic [15:0] a);
    @(negedge clk);
    ioAddr = a;
    #1;
  endtask

  function automatic logic [3:0] expIrq(input logic dis, input logic [2:0] code, input logic [3:0] n);
    return (!dis && code >= 3'd1 && code <= 3'd4) ? n : 4'd0;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    rstN = 1'b0; ioAddr = '0; wrData = '0; byteEn = '0; ioRd = 1'b0; ioWr = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10 reset state
    check("R10 rdData after reset", rdData, 16'h0000);
    probe(16'h03F0);
    check("R10 reset selects {A,B,F}", {csSerA, csSerB, csFloppy}, 3'b001);
    check("R10 reset irqs", {irqSerA, irqSerB}, 8'h00);
    probe(16'h03F8);
    check("R10 reset serial unmapped", {csSerA, csSerB}, 2'b00);
    busRead(16'h2072, rd);
    check("R10 serial cfg reset", rd, 16'h0000);
    busRead(16'hF872, rd);
    check("R10 storage reset", rd, 16'h0000);

    // Vector walk: R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      busWrite(16'h2072, VECS[i].ser, 2'b11);
      busWrite(16'h2872, VECS[i].fd, 2'b11);
      probe(VECS[i].probe);
      check($sformatf("R6 select vector %0d", i), {csSerA, csSerB, csFloppy}, VECS[i].exp);
      check($sformatf("R9 irq vector %0d", i), {irqSerA, irqSerB},
            {expIrq(VECS[i].ser[4], VECS[i].ser[7:5], 4'd4),
             expIrq(VECS[i].ser[0], VECS[i].ser[3:1], 4'd3)});
    end

    // R1 readback at even and odd address
    busWrite(16'h2072, 16'h0024, 2'b11);
    busRead(16'h2072, rd);
    check("R1 serial cfg readback", rd, 16'h0024);
    busWrite(16'h5872, 16'h1234, 2'b11);
    busRead(16'h5873, rd);
    check("R1 odd address readback", rd, 16'h1234);

    // R2 byte lanes
    busWrite(16'h5873, 16'hAB99, 2'b10);
    busRead(16'h5872, rd);
    check("R2 high lane merge", rd, 16'hAB34);
    busWrite(16'h5872, 16'hFFCD, 2'b01);
    busRead(16'h5872, rd);
    check("R2 low lane merge", rd, 16'hABCD);
    busWrite(16'h2072, 16'h5500, 2'b11);
    busWrite(16'h2072, 16'h0020, 2'b01);
    busRead(16'h2072, rd);
    check("R2 serial byte merge", rd, 16'h5520);
    probe(16'h03FA);
    check("R2 byte write drives decode", {csSerA, csSerB}, 2'b10);

    // R3 unassigned reads and hold
    busRead(16'h3072, rd);
    check("R3 window miss even", rd, 16'hFFFF);
    busRead(16'h0073, rd);
    check("R3 window miss odd", rd, 16'hFFFF);
    busRead(16'h0300, rd);
    check("R3 outside window", rd, 16'h0000);
    busRead(16'h5872, rd);
    probe(16'h3072);
    @(negedge clk);
    check("R3 hold without read", rdData, 16'hABCD);

    // R11 storage has no decode effect
    busWrite(16'h2072, 16'h0000, 2'b11);
    busWrite(16'h2872, 16'h0000, 2'b11);
    busWrite(16'hF872, 16'h5A5F, 2'b11);
    busWrite(16'h5872, 16'hFFFF, 2'b11);
    busRead(16'hF873, rd);
    check("R11 storage readback", rd, 16'h5A5F);
    probe(16'h03F8);
    check("R11 serial stays unmapped", {csSerA, csSerB, irqSerA, irqSerB}, 10'h000);
    probe(16'h03F0);
    check("R11 floppy stays enabled", csFloppy, 1'b1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule